// File: doc/BRIEF.md
# Interrupt Polarity Normalizing Front-End

This block sits between a set of asynchronous interrupt pins and a downstream interrupt controller that only accepts active-high levels and rising edges. Each pin has its own 3-bit trigger code and an enable bit, both written and read over a simple 32-bit register bus. Every pin first goes through a two-flop synchronizer. The configured condition is then detected on it and presented on `irq_o`, either as a level held high or as a single-cycle pulse.

Active-low levels are inverted. Falling edges and dual edges are turned into one-cycle pulses, so the parent never has to know the original polarity of a pin. Reads are combinational: `reg_rdata_o` reflects `reg_addr_i` in the same cycle. A write takes effect at the clock edge on which `reg_wr_i` is high.

Top module: `irq_norm_frontend`

## Requirements
- R1: After reset, every enable bit is 0, every trigger field reads back as 32'h4 (active-high level), and `irq_o` is all zero.
- R2: Enable bits are packed 32 per word starting at byte offset 0x10. Pin p is bit p%32 of the word at 0x10 + 4*(p/32). Every enable word reads back what was written, for the bits that map to existing pins.
- R3: The trigger field of pin p lives at byte offset 0x110 + 4*p. Only bits [2:0] are stored, and bits [31:3] read back as 0.
- R4: Code 3'b100 (active-high level): while the pin is enabled, `irq_o[p]` equals the pin value. A pin change appears on `irq_o` at the third rising clock edge after it (two synchronizer stages plus the output register).
- R5: Code 3'b000 (active-low level): while the pin is enabled, `irq_o[p]` is high exactly while the pin is low, with the same latency as R4.
- R6: Code 3'b010 (falling edge): each high-to-low transition produces exactly one single-cycle pulse on `irq_o[p]`. Rising transitions produce nothing.
- R7: Code 3'b110 (rising edge): each low-to-high transition produces exactly one single-cycle pulse. Falling transitions produce nothing.
- R8: Code 3'b111 (both edges): every transition in either direction produces one single-cycle pulse.
- R9: Codes 3'b001, 3'b011 and 3'b101 keep `irq_o[p]` low whatever the pin does.
- R10: A pin whose enable bit is 0 keeps `irq_o[p]` low. Setting the bit makes a pending active-high level visible one clock after the write edge.
- R11: Writes to anything other than a mapped word are ignored and read back as 0. This covers enable bits for pins beyond 125, trigger words beyond pin 125, unaligned addresses and unmapped offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 126 | Asynchronous interrupt pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 126 | Normalized requests to the parent controller |

## Verification
Each trigger code is driven with a low-to-high step followed by a high-to-low step. For every sample the full `irq_o` vector is compared, which separates the codes that respond to one direction, to both directions or to neither, and it also catches a request leaking onto a neighbouring pin. Level codes are sampled cycle by cycle around the third edge, so the synchronizer depth and the inversion can be told apart. Edge codes are checked for a pulse that is exactly one cycle wide and falls in the right cycle. The register-map patterns write all-ones to words that lie partly or wholly beyond the last pin, and to unaligned or unmapped addresses, which separates correct decoding from aliasing.

// File: rtl/irq_norm_pkg.sv
package irq_norm_pkg;

  typedef logic [2:0] trig_t;

  localparam trig_t TRIG_LVL_LO   = 3'b000;
  localparam trig_t TRIG_EDGE_FALL = 3'b010;
  localparam trig_t TRIG_LVL_HI   = 3'b100;
  localparam trig_t TRIG_EDGE_RISE = 3'b110;
  localparam trig_t TRIG_EDGE_ANY  = 3'b111;

  function automatic logic trig_is_valid(trig_t t);
    return (t == TRIG_LVL_LO) || (t == TRIG_EDGE_FALL) || (t == TRIG_LVL_HI) ||
           (t == TRIG_EDGE_RISE) || (t == TRIG_EDGE_ANY);
  endfunction

endpackage

// File: rtl/irq_norm_sync.sv
module irq_norm_sync #(
  parameter int unsigned WIDTH  = 126,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_norm_cell.sv
module irq_norm_cell
  import irq_norm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  input  logic  en_i,
  input  trig_t type_i,
  output logic  req_o
);

  logic lvl_d_q;
  logic req_q;
  logic rise, fall, hit;

  assign rise = lvl_i & ~lvl_d_q;
  assign fall = ~lvl_i & lvl_d_q;

  always_comb begin
    case (type_i)
      TRIG_LVL_LO:    hit = ~lvl_i;
      TRIG_LVL_HI:    hit = lvl_i;
      TRIG_EDGE_FALL: hit = fall;
      TRIG_EDGE_RISE: hit = rise;
      TRIG_EDGE_ANY:  hit = rise | fall;
      default:        hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      lvl_d_q <= lvl_i;
      req_q   <= hit & en_i;
    end
  end

  assign req_o = req_q;

  p_level_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && type_i == TRIG_LVL_HI) |=> (req_o == $past(lvl_i)));

  p_level_lo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && type_i == TRIG_LVL_LO) |=> (req_o == !$past(lvl_i)));

  p_fall_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && type_i == TRIG_EDGE_FALL && $past(type_i) == TRIG_EDGE_FALL) |=> !req_o);

  p_rise_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && type_i == TRIG_EDGE_RISE && $past(type_i) == TRIG_EDGE_RISE) |=> !req_o);

  p_unused_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_is_valid(type_i) |=> !req_o);

  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !req_o);

endmodule

// File: rtl/irq_norm_regs.sv
module irq_norm_regs
  import irq_norm_pkg::*;
#(
  parameter int unsigned N_PINS   = 126,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned EN_BASE  = 32'h10,
  parameter int unsigned CFG_BASE = 32'h110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PINS-1:0] en_o,
  output trig_t             type_o [N_PINS]
);

  localparam int unsigned BYTES   = DATA_W / 8;
  localparam int unsigned LANE_W  = $clog2(BYTES);
  localparam int unsigned N_WORDS = (N_PINS + DATA_W - 1) / DATA_W;
  localparam int unsigned PIN_W   = $clog2(N_PINS);
  localparam int unsigned EN_END  = EN_BASE + N_WORDS * BYTES;
  localparam int unsigned CFG_END = CFG_BASE + N_PINS * BYTES;

  logic [N_PINS-1:0] en_q;
  trig_t             type_q [N_PINS];

  logic [31:0] a;
  logic        aligned, en_hit, cfg_hit;
  logic [31:0] en_idx, cfg_idx;

  assign a       = 32'(addr_i);
  assign aligned = (addr_i[LANE_W-1:0] == '0);
  assign en_hit  = aligned && (a >= EN_BASE) && (a < EN_END);
  assign cfg_hit = aligned && (a >= CFG_BASE) && (a < CFG_END);
  assign en_idx  = (a - EN_BASE) >> LANE_W;
  assign cfg_idx = (a - CFG_BASE) >> LANE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      for (int p = 0; p < N_PINS; p++) type_q[p] <= TRIG_LVL_HI;
    end else if (wr_i) begin
      if (en_hit) begin
        for (int b = 0; b < DATA_W; b++) begin
          if (en_idx * DATA_W + b < N_PINS)
            en_q[PIN_W'(en_idx * DATA_W + b)] <= wdata_i[b];
        end
      end
      if (cfg_hit) type_q[PIN_W'(cfg_idx)] <= wdata_i[2:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (en_hit) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (en_idx * DATA_W + b < N_PINS)
          rdata_o[b] = en_q[PIN_W'(en_idx * DATA_W + b)];
      end
    end else if (cfg_hit) begin
      rdata_o = DATA_W'(type_q[PIN_W'(cfg_idx)]);
    end
  end

  assign en_o   = en_q;
  assign type_o = type_q;

  p_rd_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a >= CFG_END || (a < CFG_BASE && a >= EN_END) || a < EN_BASE) |-> (rdata_o == '0));

  p_cfg_upper_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_hit |-> (rdata_o[DATA_W-1:3] == '0));

endmodule

// File: rtl/irq_norm_frontend.sv
module irq_norm_frontend
  import irq_norm_pkg::*;
#(
  parameter int unsigned N_PINS   = 126,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SYNC_N   = 2,
  parameter int unsigned EN_BASE  = 32'h10,
  parameter int unsigned CFG_BASE = 32'h110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] irq_pin_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_PINS-1:0] irq_o
);

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] pin_en;
  trig_t             pin_type [N_PINS];

  irq_norm_sync #(
    .WIDTH (N_PINS),
    .STAGES(SYNC_N)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_pin_i),
    .sync_o (pin_sync)
  );

  irq_norm_regs #(
    .N_PINS  (N_PINS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .EN_BASE (EN_BASE),
    .CFG_BASE(CFG_BASE)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .en_o   (pin_en),
    .type_o (pin_type)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_cell
    irq_norm_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (pin_sync[p]),
      .en_i  (pin_en[p]),
      .type_i(pin_type[p]),
      .req_o (irq_o[p])
    );
  end

endmodule

// File: tb/irq_norm_frontend_tb.sv
module irq_norm_frontend_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 126;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          wr = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;
  logic [31:0]   en_sh [4];
  int            n_chk = 0;
  int            n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_norm_frontend u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_pin_i  (pins),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    chk(rdata == exp, req, 128'(rdata), 128'(exp));
  endtask

  task automatic set_en(input int p, input bit on);
    en_sh[p/32][p%32] = on;
    reg_wr(12'(32'h10 + 4*(p/32)), en_sh[p/32]);
  endtask

  task automatic set_type(input int p, input logic [2:0] t);
    reg_wr(12'(32'h110 + 4*p), {29'd0, t});
  endtask

  function automatic logic [127:0] bitm(input int p);
    return 128'(1) << p;
  endfunction

  // pin change driven at a negedge: irq visible after the third posedge, for one cycle
  task automatic expect_pulse(input int p, input string req);
    for (int s = 1; s <= 4; s++) begin
      step();
      chk(128'(irq) == ((s == 3) ? bitm(p) : 128'(0)), req, 128'(irq), (s == 3) ? bitm(p) : 128'(0));
    end
  endtask

  task automatic expect_quiet(input int steps, input string req);
    for (int s = 0; s < steps; s++) begin
      step();
      chk(irq == '0, req, 128'(irq), 128'(0));
    end
  endtask

  task automatic t_reset();
    for (int w = 0; w < 4; w++) reg_rd(12'(32'h10 + 4*w), 32'h0, "R1 enable reset");
    reg_rd(12'h110, 32'h4, "R1 type reset pin0");
    reg_rd(12'h304, 32'h4, "R1 type reset pin125");
    chk(irq == '0, "R1 irq reset", 128'(irq), 128'(0));
  endtask

  task automatic t_regmap();
    reg_wr(12'h14, 32'hA5A5_0001);
    reg_rd(12'h14, 32'hA5A5_0001, "R2 enable word1 readback");
    reg_rd(12'h10, 32'h0, "R2 word0 untouched");
    reg_wr(12'h14, 32'h0);
    reg_wr(12'h11C, 32'hFFFF_FFF9);
    reg_rd(12'h11C, 32'h1, "R3 type field pin3 low bits only");
    reg_rd(12'h118, 32'h4, "R3 neighbour pin2 untouched");
    reg_wr(12'h11C, 32'h4);
  endtask

  task automatic t_beyond();
    reg_wr(12'h1C, 32'hFFFF_FFFF);
    reg_rd(12'h1C, 32'h3FFF_FFFF, "R11 bits past pin125 read zero");
    reg_wr(12'h308, 32'h6);
    reg_rd(12'h308, 32'h0, "R11 type word beyond pin125");
    reg_wr(12'h000, 32'hFFFF_FFFF);
    reg_rd(12'h000, 32'h0, "R11 unmapped low offset");
    reg_wr(12'h800, 32'hFFFF_FFFF);
    reg_rd(12'h800, 32'h0, "R11 unmapped high offset");
    reg_wr(12'h112, 32'h0);
    reg_rd(12'h110, 32'h4, "R11 unaligned write ignored");
    reg_wr(12'h20, 32'hFFFF_FFFF);
    reg_rd(12'h20, 32'h0, "R11 enable word past bank");
    expect_quiet(4, "R11 no request from ignored writes");
    reg_wr(12'h1C, 32'h0);
  endtask

  task automatic t_level_hi();
    set_type(0, 3'b100);
    set_en(0, 1'b1);
    pins[0] = 1'b1;
    step(); step();
    chk(irq == '0, "R4 not before third edge", 128'(irq), 128'(0));
    step();
    chk(128'(irq) == bitm(0), "R4 level high asserted", 128'(irq), bitm(0));
    step(); step();
    chk(128'(irq) == bitm(0), "R4 level held", 128'(irq), bitm(0));
    pins[0] = 1'b0;
    step(); step(); step();
    chk(irq == '0, "R4 level released", 128'(irq), 128'(0));
    set_en(0, 1'b0);
  endtask

  task automatic t_level_lo();
    set_type(5, 3'b000);
    set_en(5, 1'b1);
    step();
    chk(128'(irq) == bitm(5), "R5 active low asserted", 128'(irq), bitm(5));
    pins[5] = 1'b1;
    step(); step();
    chk(128'(irq) == bitm(5), "R5 still high before third edge", 128'(irq), bitm(5));
    step();
    chk(irq == '0, "R5 deasserted on high pin", 128'(irq), 128'(0));
    pins[5] = 1'b0;
    step(); step(); step();
    chk(128'(irq) == bitm(5), "R5 reasserted on low pin", 128'(irq), bitm(5));
    set_en(5, 1'b0);
    step();
    chk(irq == '0, "R10 disable drops level", 128'(irq), 128'(0));
  endtask

  task automatic t_fall();
    set_type(40, 3'b010);
    set_en(40, 1'b1);
    pins[40] = 1'b1;
    expect_quiet(4, "R6 rising ignored");
    pins[40] = 1'b0;
    expect_pulse(40, "R6 falling pulse");
    set_en(40, 1'b0);
  endtask

  task automatic t_rise();
    set_type(125, 3'b110);
    set_en(125, 1'b1);
    pins[125] = 1'b1;
    expect_pulse(125, "R7 rising pulse");
    expect_quiet(3, "R7 no repeat while held");
    pins[125] = 1'b0;
    expect_quiet(4, "R7 falling ignored");
    set_en(125, 1'b0);
  endtask

  task automatic t_dual();
    set_type(64, 3'b111);
    set_en(64, 1'b1);
    pins[64] = 1'b1;
    expect_pulse(64, "R8 pulse on rise");
    pins[64] = 1'b0;
    expect_pulse(64, "R8 pulse on fall");
    set_en(64, 1'b0);
  endtask

  task automatic t_unused();
    logic [2:0] codes [3] = '{3'b001, 3'b011, 3'b101};
    set_en(7, 1'b1);
    for (int c = 0; c < 3; c++) begin
      set_type(7, codes[c]);
      pins[7] = 1'b1;
      expect_quiet(4, "R9 unused code rise/high");
      pins[7] = 1'b0;
      expect_quiet(4, "R9 unused code fall/low");
    end
    set_en(7, 1'b0);
  endtask

  task automatic t_disabled();
    set_type(20, 3'b110);
    pins[20] = 1'b1;
    expect_quiet(4, "R10 disabled edge pin");
    set_type(20, 3'b100);
    expect_quiet(2, "R10 disabled level pin");
    set_en(20, 1'b1);
    step();
    chk(128'(irq) == bitm(20), "R10 enable exposes level", 128'(irq), bitm(20));
    set_en(20, 1'b0);
    pins[20] = 1'b0;
    step();
    chk(irq == '0, "R10 disable again", 128'(irq), 128'(0));
  endtask

  initial begin
    for (int w = 0; w < 4; w++) en_sh[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_beyond();
    t_level_hi();
    t_level_lo();
    t_fall();
    t_rise();
    t_dual();
    t_unused();
    t_disabled();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule